// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

A register-mapped arithmetic helper that a processor writes operands into and later reads results back from. It performs an unsigned 8-bit by 8-bit multiply or an unsigned 16-bit by 8-bit divide. The hardware is one bit-serial shift-add / shift-subtract engine, so each operation takes a fixed number of cycles: eight for a multiply and sixteen for a divide.

Writing the second multiply operand or the divisor is the start command. Software sets the other operands first, issues the start, then either waits out the known latency or watches `busy`. Two 16-bit result registers, quotient and product/remainder, are read one byte at a time through a combinational read port. During an operation both result registers hold well-defined partial values. A start that arrives while the engine is running is dropped. The register side effect tied to that write still takes place.

Top module: `muldiv_unit`

## Requirements
- R1: A write to `wr_addr` 0 stores operand A and nothing else: while idle, both result registers and `busy` are unchanged by it.
- R2: A write to `wr_addr` 1 (multiplier) always clears the product/remainder register, even while busy; while busy the remainder of that write is discarded.
- R3: An accepted multiply start loads the quotient register with {B, A}, which holds for the whole operation; eight cycles later the product/remainder register holds A*B.
- R4: Writes to `wr_addr` 2 (dividend low byte) and `wr_addr` 3 (dividend high byte) store the dividend only; while idle the result registers are unchanged.
- R5: A write to `wr_addr` 4 (divisor) always copies the stored dividend into the product/remainder register, even while busy; while busy the remainder of that write is discarded.
- R6: An accepted divide start takes sixteen cycles and leaves dividend/divisor in the quotient register and the remainder in the product/remainder register.
- R7: A divide by zero yields quotient 0xFFFF and a remainder equal to the dividend.
- R8: `rd_addr` selects the read byte: 0 quotient low, 1 quotient high, 2 product/remainder low, 3 product/remainder high.
- R9: `busy` rises in the cycle after an accepted start and stays high for exactly eight (multiply) or sixteen (divide) cycles. A start seen while busy neither restarts nor lengthens the run.
- R10: After reset, `busy` is low and both result registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select (0 A, 1 B/start multiply, 2 dividend low, 3 dividend high, 4 divisor/start divide) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read byte select |
| rd_data | output | 8 | Selected result byte (combinational) |
| busy | output | 1 | Operation in progress |

## Verification
Two events can land on the same clock edge: a register write that touches the product/remainder register (the multiplier-write clear or the divisor-write dividend copy), and an engine iteration that updates the same register. The bench provokes this by issuing those writes partway through a running multiply and a running divide. It then checks three things: the register holds exactly the cleared or copied value on the next cycle, the quotient register is untouched, and the run still ends at its original cycle count.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [OPW-1:0] wr_data,
  input  logic [1:0]     rd_addr,
  output logic [OPW-1:0] rd_data,
  output logic           busy
);
  localparam int RW = 2 * OPW;
  localparam int SW = 3 * OPW;
  localparam int CW = $clog2(RW + 1);

  logic [OPW-1:0] op_a;
  logic [RW-1:0]  dvd, quot, prod;
  logic [SW-1:0]  shreg;
  logic [CW-1:0]  cnt;
  logic           is_div;

  logic           wr_b, wr_v;
  logic [SW-1:0]  sh_next;
  logic           fits;
  logic [CW-1:0]  midx;
  logic [RW-1:0]  addend;

  assign busy    = (cnt != '0);
  assign wr_b    = wr_en && (wr_addr == 3'd1);
  assign wr_v    = wr_en && (wr_addr == 3'd4);
  assign sh_next = shreg >> 1;
  assign fits    = ({{OPW{1'b0}}, prod} >= sh_next);
  assign midx    = CW'(OPW) - cnt;
  assign addend  = {{OPW{1'b0}}, op_a} << midx;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = quot[OPW-1:0];
      2'd1:    rd_data = quot[RW-1:OPW];
      2'd2:    rd_data = prod[OPW-1:0];
      default: rd_data = prod[RW-1:OPW];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a   <= '0;
      dvd    <= '0;
      quot   <= '0;
      prod   <= '0;
      shreg  <= '0;
      cnt    <= '0;
      is_div <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 3'd0) op_a <= wr_data;
      if (wr_en && wr_addr == 3'd2) dvd[OPW-1:0] <= wr_data;
      if (wr_en && wr_addr == 3'd3) dvd[RW-1:OPW] <= wr_data;

      if (busy) begin
        cnt <= cnt - 1'b1;
        if (is_div) begin
          shreg <= sh_next;
          quot  <= {quot[RW-2:0], fits};
          if (fits) prod <= prod - sh_next[RW-1:0];
        end else begin
          shreg <= sh_next;
          if (shreg[0]) prod <= prod + addend;
        end
      end

      if (wr_b) begin
        prod <= '0;
        if (!busy) begin
          quot   <= {wr_data, op_a};
          shreg  <= {{RW{1'b0}}, wr_data};
          cnt    <= CW'(OPW);
          is_div <= 1'b0;
        end
      end

      if (wr_v) begin
        prod <= dvd;
        if (!busy) begin
          shreg  <= {wr_data, {RW{1'b0}}};
          cnt    <= CW'(RW);
          is_div <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_props.sv
module muldiv_unit_props #(
  parameter int OPW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [OPW-1:0]   wr_data,
  input logic [OPW-1:0]   op_a,
  input logic [2*OPW-1:0] dvd,
  input logic [2*OPW-1:0] quot,
  input logic [2*OPW-1:0] prod,
  input logic             busy
);
  localparam int CW = $clog2(2 * OPW + 1);

  logic          go_m, go_d;
  logic [CW:0]   run;
  logic          kind;

  assign go_m = wr_en && wr_addr == 3'd1 && !busy;
  assign go_d = wr_en && wr_addr == 3'd4 && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      kind <= 1'b0;
    end else if (go_m || go_d) begin
      run  <= '0;
      kind <= go_d;
    end else if (busy) begin
      run <= run + 1'b1;
    end
  end

  a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (go_m || go_d) |=> busy);

  a_r9_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == (kind ? (CW+1)'(2*OPW) : (CW+1)'(OPW))));

  a_r2_clear_prod: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> (prod == '0));

  a_r5_copy_dividend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4) |=> (prod == $past(dvd)));

  a_r3_quot_load: assert property (@(posedge clk) disable iff (!rst_n)
    go_m |=> (quot == {$past(wr_data), $past(op_a)}));

  a_r3_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !kind) |=> $stable(quot));

  a_r1_a_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && !busy) |=> ($stable(prod) && $stable(quot) && !busy));
endmodule

bind muldiv_unit muldiv_unit_props #(.OPW(OPW)) u_props (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .op_a(op_a), .dvd(dvd), .quot(quot), .prod(prod), .busy(busy)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  muldiv_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd16(input logic hi_prod, output int v);
    logic [7:0] lo;
    rd_addr = {hi_prod, 1'b0}; #1; lo = rd_data;
    rd_addr = {hi_prod, 1'b1}; #1;
    v = {rd_data, lo};
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    int q, p;
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R10 busy", busy, 0);
    chk("R10 quot", q, 0);
    chk("R10 prod", p, 0);
  endtask

  task automatic t_mul(input int a, input int b);
    int q, p, c0;
    wr(3'd0, 8'(a));
    wr(3'd1, 8'(b));
    c0 = cyc;
    rd16(1'b0, q);
    chk("R3 quot={B,A}", q, (b << 8) | a);
    chk("R9 busy after start", busy, 1);
    wait_idle();
    chk("R9 mul cycles", cyc - c0, 8);
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R3 product", p, a * b);
    chk("R3 quot held", q, (b << 8) | a);
  endtask

  task automatic t_div(input int d, input int v);
    int q, p, c0;
    wr(3'd2, 8'(d));
    wr(3'd3, 8'(d >> 8));
    wr(3'd4, 8'(v));
    c0 = cyc;
    rd16(1'b1, p);
    chk("R5 dividend copied", p, d);
    wait_idle();
    chk("R9 div cycles", cyc - c0, 16);
    rd16(1'b0, q); rd16(1'b1, p);
    if (v == 0) begin
      chk("R7 div0 quotient", q, 16'hFFFF);
      chk("R7 div0 remainder", p, d);
    end else begin
      chk("R6 quotient", q, d / v);
      chk("R6 remainder", p, d % v);
    end
  endtask

  task automatic t_bytes();
    wr(3'd0, 8'h3C); wr(3'd1, 8'hA5);
    wait_idle();
    rd_addr = 2'd0; #1; chk("R8 quot lo", rd_data, 8'h3C);
    rd_addr = 2'd1; #1; chk("R8 quot hi", rd_data, 8'hA5);
    rd_addr = 2'd2; #1; chk("R8 prod lo", rd_data, (8'h3C * 8'hA5) & 8'hFF);
    rd_addr = 2'd3; #1; chk("R8 prod hi", rd_data, (8'h3C * 8'hA5) >> 8);
  endtask

  task automatic t_store_only();
    int q0, p0, q, p;
    rd16(1'b0, q0); rd16(1'b1, p0);
    wr(3'd0, 8'h77);
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R1 quot unchanged", q, q0);
    chk("R1 prod unchanged", p, p0);
    chk("R1 no start", busy, 0);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22);
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R4 quot unchanged", q, q0);
    chk("R4 prod unchanged", p, p0);
    chk("R4 no start", busy, 0);
  endtask

  task automatic t_mul_collide();
    int q, p, c0;
    wr(3'd0, 8'd5); wr(3'd1, 8'd7);
    c0 = cyc;
    @(negedge clk); @(negedge clk);
    wr(3'd1, 8'd99);
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R2 prod cleared while busy", p, 0);
    chk("R2 start ignored quot", q, (7 << 8) | 5);
    wait_idle();
    chk("R9 run not restarted", cyc - c0, 8);
    rd16(1'b0, q);
    chk("R2 quot after ignored", q, (7 << 8) | 5);
  endtask

  task automatic t_div_collide_mul();
    int q, p, c0;
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    wr(3'd0, 8'd3); wr(3'd1, 8'd4);
    c0 = cyc;
    @(negedge clk);
    wr(3'd4, 8'd9);
    rd16(1'b0, q); rd16(1'b1, p);
    chk("R5 copy while busy", p, 16'h1234);
    chk("R5 start ignored quot", q, (4 << 8) | 3);
    wait_idle();
    chk("R9 mul length kept", cyc - c0, 8);
    rd16(1'b0, q);
    chk("R5 no divide ran", q, (4 << 8) | 3);
  endtask

  task automatic t_mul_collide_div();
    int p, c0;
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    wr(3'd4, 8'd3);
    c0 = cyc;
    repeat (5) @(negedge clk);
    wr(3'd1, 8'd2);
    rd16(1'b1, p);
    chk("R2 clear during divide", p, 0);
    wait_idle();
    chk("R9 div length kept", cyc - c0, 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul(0, 0);
    t_mul(255, 255);
    t_mul(13, 11);
    t_mul(128, 2);
    t_mul(1, 255);
    t_div(16'hFFFF, 1);
    t_div(1000, 7);
    t_div(16'hABCD, 255);
    t_div(5, 10);
    t_div(16'h1234, 0);
    t_bytes();
    t_store_only();
    t_mul_collide();
    t_div_collide_mul();
    t_mul_collide_div();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule